// File: doc/BRIEF.md
# Class-of-Service Cache Way Mask Table

This block keeps the way-allocation masks for two cache levels, one mask per class of service at each level. A core presents a class ID, taken from its shared association register, together with a flag that says whether the access is a code fetch or a data fetch. The block answers in the same cycle with the level-2 way mask and the level-3 way mask that the cache controllers must enforce. Software programs entries through a write port and inspects raw entries through a read port.

Not every value that software writes is accepted. The block refuses a mask whose set bits do not form a single unbroken run. It also refuses an all-zero mask and any attempt to change class 0, which always allows every way. A class above a level's top class falls back to the all-ones mask at that level only. A split mode pairs the level-3 entries so that each class gets a separate data mask and a separate code mask. In that mode only half the level-3 class range is usable, and the level-2 side is unchanged.

Top module: `cos_mask_table`

## Requirements
- R1: After reset every entry of both tables reads all ones (`(1 << CBM_LEN) - 1`), split mode is off and `wr_err` is low.
- R2: Entry 0 of either table never changes. A write to index 0 is refused. Class 0 looks up the all-ones mask at both levels in either mode.
- R3: A write with `wr_en` high, whose mask is one contiguous run of ones, is stored at index `wr_idx` of the table chosen by `wr_l3` (1 = level 3). The read port shows it from the next cycle on. `rd_mask` is combinational from `rd_l3` and `rd_idx`.
- R4: A write whose mask is zero or has more than one run of ones is refused and leaves the entry unchanged. Every refused write raises `wr_err` for exactly the one cycle after the write cycle.
- R5: `l2_mask` and `l3_mask` are combinational from `lk_cos` and `lk_code`. Both are driven from the same class ID in the same cycle.
- R6: A class above the level-2 top class (`L2_ENTRIES-1`) gives an all-ones `l2_mask`, while `l3_mask` still comes from the level-3 entry of that class.
- R7: With split mode off, a class above `L3_ENTRIES-1` gives an all-ones `l3_mask`. Otherwise `l3_mask` is level-3 entry `lk_cos`.
- R8: With split mode on, class n takes level-3 entry 2n when `lk_code` is 0 (data) and entry 2n+1 when `lk_code` is 1 (code).
- R9: With split mode on, a class of `L3_ENTRIES/2` or more gives an all-ones `l3_mask`. The level-2 lookup is unaffected by the mode.
- R10: With split mode on, a write to level-3 index 1 (class 0 code mask) is refused with `wr_err`.
- R11: A level-2 write with `wr_idx` of `L2_ENTRIES` or more is refused with `wr_err`. A level-2 read of such an index returns all ones.
- R12: A cycle with `mode_wr` high loads `mode_cdp` into the split-mode flag, which governs lookups and writes from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Load the split-mode flag |
| mode_cdp | input | 1 | New split-mode value (1 = separate code/data level-3 masks) |
| wr_en | input | 1 | Mask write strobe |
| wr_l3 | input | 1 | Write target: 1 = level-3 table, 0 = level-2 table |
| wr_idx | input | IDX_W | Raw entry index of the write |
| wr_mask | input | CBM_LEN | Mask to write |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| rd_l3 | input | 1 | Read target: 1 = level-3 table, 0 = level-2 table |
| rd_idx | input | IDX_W | Raw entry index to read |
| rd_mask | output | CBM_LEN | Stored mask at the read index |
| lk_cos | input | COS_W | Class ID of the access |
| lk_code | input | 1 | 1 = code fetch, 0 = data fetch |
| l2_mask | output | CBM_LEN | Level-2 way mask to enforce |
| l3_mask | output | CBM_LEN | Level-3 way mask to enforce |

## Verification
The lookup and read outputs are due in the same cycle as their inputs. A write or a mode change takes effect on the next rising edge. `wr_err` is due exactly one edge after a refused write and drops one edge later. The bench drives inputs 2 ns after each rising edge and compares every output with a behavioural model on the falling edge. By then the model has absorbed the same edge, so each result is checked in the cycle it is due. Directed checks sample 2 ns after the edge that completes a write, which is the first point where the stored value and the error pulse are both visible.

// File: rtl/cos_mask_pkg.sv
package cos_mask_pkg;
   // true when the set bits of m form exactly one run of ones
   function automatic bit one_run(input logic [63:0] m, input int w);
      int runs;
      runs = 0;
      for (int i = 0; i < w; i++)
         if (m[i] && (i == 0 || !m[i-1])) runs++;
      return runs == 1;
   endfunction
endpackage

// File: rtl/cos_cbm_validator.sv
module cos_cbm_validator #(
   parameter int W = 8
) (
   input  logic [W-1:0] mask,
   output logic         legal
);
   logic [W-1:0] fill;
   always_comb begin
      fill  = mask | (mask - W'(1));
      legal = (mask != '0) && (((fill + W'(1)) & mask) == '0);
   end
endmodule

// File: rtl/cos_mask_bank.sv
module cos_mask_bank #(
   parameter int W  = 8,
   parameter int N  = 16,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] ra,
   output logic [W-1:0]  rd_a,
   input  logic [AW-1:0] rb,
   output logic [W-1:0]  rd_b
);
   localparam logic [W-1:0] DEF = {W{1'b1}};

   if (N != (1 << AW)) begin : g_bad_depth
      $error("cos_mask_bank: N must equal 2**AW");
   end

   logic [W-1:0] ent [N];

   for (genvar i = 0; i < N; i++) begin : g_ent
      if (i == 0) begin : g_pinned
         assign ent[i] = DEF;
      end else begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               ent[i] <= DEF;
            else if (we && waddr == AW'(i))
               ent[i] <= wdata;
         end
      end
   end

   assign rd_a = ent[ra];
   assign rd_b = ent[rb];
endmodule

// File: rtl/cos_mask_table.sv
module cos_mask_table #(
   parameter int CBM_LEN    = 8,
   parameter int L3_ENTRIES = 16,
   parameter int L2_ENTRIES = 8,
   parameter int COS_W      = 5,
   localparam int IDX_W     = $clog2(L3_ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_wr,
   input  logic               mode_cdp,
   input  logic               wr_en,
   input  logic               wr_l3,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [CBM_LEN-1:0] wr_mask,
   output logic               wr_err,
   input  logic               rd_l3,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [CBM_LEN-1:0] rd_mask,
   input  logic [COS_W-1:0]   lk_cos,
   input  logic               lk_code,
   output logic [CBM_LEN-1:0] l2_mask,
   output logic [CBM_LEN-1:0] l3_mask
);
   localparam int L2_AW = $clog2(L2_ENTRIES);
   localparam logic [CBM_LEN-1:0] DEF = {CBM_LEN{1'b1}};
   localparam logic [COS_W-1:0] L3_TOP  = COS_W'(L3_ENTRIES - 1);
   localparam logic [COS_W-1:0] L2_TOP  = COS_W'(L2_ENTRIES - 1);
   localparam logic [COS_W-1:0] CDP_TOP = COS_W'(L3_ENTRIES / 2 - 1);

   if (CBM_LEN < 1 || CBM_LEN > 64) begin : g_bad_len
      $error("cos_mask_table: CBM_LEN out of range");
   end
   if (L3_ENTRIES < 4 || L3_ENTRIES > 128) begin : g_bad_l3
      $error("cos_mask_table: L3_ENTRIES out of range");
   end
   if (L2_ENTRIES < 2 || L2_ENTRIES > 64 || L2_ENTRIES > L3_ENTRIES) begin : g_bad_l2
      $error("cos_mask_table: L2_ENTRIES out of range");
   end
   if (COS_W < IDX_W) begin : g_bad_cos
      $error("cos_mask_table: COS_W narrower than level-3 index");
   end

   // split-mode flag
   logic cdp_q;
   always_ff @(posedge clk) begin
      if (!rst_n)       cdp_q <= 1'b0;
      else if (mode_wr) cdp_q <= mode_cdp;
   end

   // write legality
   logic mask_ok, idx_ok, wr_ok;
   cos_cbm_validator #(.W(CBM_LEN)) u_val (.mask(wr_mask), .legal(mask_ok));

   always_comb begin
      idx_ok = (wr_idx != '0);
      if (wr_l3 && cdp_q && wr_idx == IDX_W'(1)) idx_ok = 1'b0;
      if (!wr_l3 && wr_idx > IDX_W'(L2_ENTRIES - 1)) idx_ok = 1'b0;
      wr_ok = mask_ok && idx_ok;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) wr_err <= 1'b0;
      else        wr_err <= wr_en && !wr_ok;
   end

   // level-3 table
   logic [IDX_W-1:0]   l3_lk_addr;
   logic [CBM_LEN-1:0] l3_rd, l3_lk;
   logic               l3_in;

   always_comb begin
      if (cdp_q) begin
         l3_lk_addr = {lk_cos[IDX_W-2:0], lk_code};
         l3_in      = lk_cos <= CDP_TOP;
      end else begin
         l3_lk_addr = lk_cos[IDX_W-1:0];
         l3_in      = lk_cos <= L3_TOP;
      end
   end

   cos_mask_bank #(.W(CBM_LEN), .N(L3_ENTRIES), .AW(IDX_W)) u_l3 (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && wr_ok && wr_l3), .waddr(wr_idx), .wdata(wr_mask),
      .ra(rd_idx), .rd_a(l3_rd),
      .rb(l3_lk_addr), .rd_b(l3_lk)
   );

   // level-2 table
   logic [CBM_LEN-1:0] l2_rd, l2_lk;

   cos_mask_bank #(.W(CBM_LEN), .N(L2_ENTRIES), .AW(L2_AW)) u_l2 (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && wr_ok && !wr_l3), .waddr(wr_idx[L2_AW-1:0]), .wdata(wr_mask),
      .ra(rd_idx[L2_AW-1:0]), .rd_a(l2_rd),
      .rb(lk_cos[L2_AW-1:0]), .rd_b(l2_lk)
   );

   // outputs
   always_comb begin
      if (rd_l3)                                rd_mask = l3_rd;
      else if (rd_idx <= IDX_W'(L2_ENTRIES-1))  rd_mask = l2_rd;
      else                                      rd_mask = DEF;

      l2_mask = (lk_cos <= L2_TOP) ? l2_lk : DEF;
      l3_mask = (l3_in && lk_cos != '0) ? l3_lk : DEF;
   end
endmodule

// File: rtl/cos_mask_table_chk.sv
module cos_mask_table_chk #(
   parameter int CBM_LEN    = 8,
   parameter int L3_ENTRIES = 16,
   parameter int L2_ENTRIES = 8,
   parameter int COS_W      = 5,
   localparam int IDX_W     = $clog2(L3_ENTRIES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [CBM_LEN-1:0] wr_mask,
   input logic               wr_err,
   input logic [COS_W-1:0]   lk_cos,
   input logic [CBM_LEN-1:0] l2_mask,
   input logic [CBM_LEN-1:0] l3_mask
);
   import cos_mask_pkg::*;
   localparam logic [CBM_LEN-1:0] DEF = {CBM_LEN{1'b1}};

   // R4
   bad_mask_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !one_run(64'(wr_mask), CBM_LEN) |=> wr_err);

   // R4
   err_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(wr_en));

   // R2
   class0_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_cos == '0 |-> (l2_mask == DEF && l3_mask == DEF));

   // R6
   l2_beyond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_cos > COS_W'(L2_ENTRIES - 1) |-> l2_mask == DEF);

   // R3
   l3_legal_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      one_run(64'(l3_mask), CBM_LEN) && one_run(64'(l2_mask), CBM_LEN));
endmodule

bind cos_mask_table cos_mask_table_chk #(
   .CBM_LEN(CBM_LEN), .L3_ENTRIES(L3_ENTRIES),
   .L2_ENTRIES(L2_ENTRIES), .COS_W(COS_W)
) u_chk (.*);

// File: tb/cos_mask_table_bench.sv
`timescale 1ns/1ps
module cos_mask_table_bench;
   localparam int W = 8, N3 = 16, N2 = 8, CW = 5, IW = 4;
   localparam int DEF = 255;

   logic clk = 0, rst_n = 0;
   logic mode_wr = 0, mode_cdp = 0, wr_en = 0, wr_l3 = 0, rd_l3 = 0, lk_code = 0;
   logic [IW-1:0] wr_idx = 0, rd_idx = 0;
   logic [W-1:0]  wr_mask = 0;
   logic [CW-1:0] lk_cos = 0;
   logic          wr_err;
   logic [W-1:0]  rd_mask, l2_mask, l3_mask;

   cos_mask_table #(.CBM_LEN(W), .L3_ENTRIES(N3), .L2_ENTRIES(N2), .COS_W(CW)) u_cos_mask_table (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_cdp(mode_cdp),
      .wr_en(wr_en), .wr_l3(wr_l3), .wr_idx(wr_idx), .wr_mask(wr_mask), .wr_err(wr_err),
      .rd_l3(rd_l3), .rd_idx(rd_idx), .rd_mask(rd_mask),
      .lk_cos(lk_cos), .lk_code(lk_code), .l2_mask(l2_mask), .l3_mask(l3_mask));

   always #5 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int m3 [N3];
   int m2 [N2];
   bit cdp, e_err;

   function automatic bit legal_mask(int m);
      int runs = 0;
      for (int i = 0; i < W; i++)
         if (m[i] && (i == 0 || !m[i-1])) runs++;
      return runs == 1;
   endfunction

   function automatic int e_l2(int c);
      if (c == 0 || c >= N2) return DEF;
      return m2[c];
   endfunction

   function automatic int e_l3(int c, int code);
      if (c == 0) return DEF;
      if (!cdp) return (c >= N3) ? DEF : m3[c];
      return (c >= N3/2) ? DEF : m3[2*c + code];
   endfunction

   function automatic int e_rd(int l3, int i);
      if (l3) return m3[i];
      return (i < N2) ? m2[i] : DEF;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N3; i++) m3[i] <= DEF;
         for (int i = 0; i < N2; i++) m2[i] <= DEF;
         cdp <= 0; e_err <= 0;
      end else begin
         bit ok;
         ok = legal_mask(int'(wr_mask)) && wr_idx != 0 &&
              !(wr_l3 && cdp && wr_idx == 1) && (wr_l3 || wr_idx < N2);
         e_err <= wr_en && !ok;
         if (wr_en && ok) begin
            if (wr_l3) m3[wr_idx] <= int'(wr_mask);
            else       m2[wr_idx] <= int'(wr_mask);
         end
         if (mode_wr) cdp <= mode_cdp;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R6 l2_mask", int'(l2_mask), e_l2(int'(lk_cos)));
         check("R8 l3_mask", int'(l3_mask), e_l3(int'(lk_cos), int'(lk_code)));
         check("R3 rd_mask", int'(rd_mask), e_rd(int'(rd_l3), int'(rd_idx)));
         check("R4 wr_err", int'(wr_err), int'(e_err));
      end
   end

   task automatic wr(input bit l3, input int idx, input int m);
      @(posedge clk); #2;
      wr_en = 1; wr_l3 = l3; wr_idx = IW'(idx); wr_mask = W'(m);
      @(posedge clk); #2;
      wr_en = 0;
   endtask

   task automatic look(input int c, input bit code);
      lk_cos = CW'(c); lk_code = code; #1;
   endtask

   task automatic rd(input bit l3, input int idx);
      rd_l3 = l3; rd_idx = IW'(idx); #1;
   endtask

   task automatic set_mode(input bit v);
      @(posedge clk); #2; mode_wr = 1; mode_cdp = v;
      @(posedge clk); #2; mode_wr = 0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      // R1 reset state
      rd(1, 7); check("R1 l3 entry after reset", int'(rd_mask), DEF);
      rd(0, 3); check("R1 l2 entry after reset", int'(rd_mask), DEF);
      check("R1 wr_err after reset", int'(wr_err), 0);
      look(5, 0); check("R1 l3 lookup after reset", int'(l3_mask), DEF);

      // R3 legal writes
      wr(1, 5, 'h3C); rd(1, 5); check("R3 l3 stored", int'(rd_mask), 'h3C);
      check("R3 no error", int'(wr_err), 0);
      wr(0, 3, 'h0F); rd(0, 3); check("R3 l2 stored", int'(rd_mask), 'h0F);
      // R5 one class, both levels, same cycle
      wr(1, 3, 'hF0);
      look(3, 0); check("R5 l2 pair", int'(l2_mask), 'h0F);
      check("R5 l3 pair", int'(l3_mask), 'hF0);

      // R4 illegal masks
      wr(1, 5, 'h05); check("R4 split mask err", int'(wr_err), 1);
      rd(1, 5); check("R4 entry kept", int'(rd_mask), 'h3C);
      @(posedge clk); #2; check("R4 pulse one cycle", int'(wr_err), 0);
      wr(1, 5, 'h00); check("R4 zero mask err", int'(wr_err), 1);
      rd(1, 5); check("R4 entry kept after zero", int'(rd_mask), 'h3C);

      // R2 entry 0
      wr(1, 0, 'h01); check("R2 class0 write err", int'(wr_err), 1);
      rd(1, 0); check("R2 entry0 open", int'(rd_mask), DEF);
      look(0, 1); check("R2 class0 l3", int'(l3_mask), DEF);

      // R11 level-2 index range
      wr(0, 9, 'h03); check("R11 l2 index err", int'(wr_err), 1);
      rd(0, 9); check("R11 l2 read beyond", int'(rd_mask), DEF);

      // R6 / R7 beyond top class
      wr(1, 10, 'h1E);
      look(10, 0); check("R6 l2 default", int'(l2_mask), DEF);
      check("R6 l3 still used", int'(l3_mask), 'h1E);
      look(20, 0); check("R7 l3 default", int'(l3_mask), DEF);

      // R12 / R8 split mode
      wr(1, 4, 'h07);
      set_mode(1);
      look(2, 0); check("R8 data entry 4", int'(l3_mask), 'h07);
      look(2, 1); check("R8 code entry 5", int'(l3_mask), 'h3C);
      check("R12 mode in effect", int'(l3_mask), 'h3C);
      // R9 upper half unusable, level 2 unaffected
      look(10, 0); check("R9 l3 default in split", int'(l3_mask), DEF);
      look(3, 1); check("R9 l2 unaffected", int'(l2_mask), 'h0F);
      // R10
      wr(1, 1, 'h0F); check("R10 class0 code err", int'(wr_err), 1);
      rd(1, 1); check("R10 entry1 kept", int'(rd_mask), DEF);
      set_mode(0);
      look(5, 1); check("R12 mode off", int'(l3_mask), 'h3C);

      // mixed traffic, compared each clock against the model
      for (int k = 0; k < 400; k++) begin
         @(posedge clk); #2;
         wr_en = ($urandom % 3) == 0; wr_l3 = $urandom; wr_idx = IW'($urandom);
         wr_mask = W'($urandom);
         if ($urandom % 2) wr_mask = W'(((1 << ($urandom % 4 + 1)) - 1) << ($urandom % 4));
         mode_wr = ($urandom % 20) == 0; mode_cdp = $urandom;
         rd_l3 = $urandom; rd_idx = IW'($urandom);
         lk_cos = CW'($urandom); lk_code = $urandom;
      end
      @(posedge clk); #2; wr_en = 0; mode_wr = 0;
      @(posedge clk); #2;
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule